// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block carries out the memory side of three control-transfer operations in a 32-bit processor core. A software trap saves the processor status word and the return address on the supervisor stack, fetches a handler address from a vector table, and loads it into the program counter. An emulator trap follows the same save sequence but uses a fixed slot in the table. A trap return pops the program counter and then the status word back off the stack.

The sequencer owns the program counter, the status word with its supervisor-stack flag and interrupt-enable flag, the supervisor stack pointer and the vector table base. All of these come out of reset with parameter values. The pipeline pulses `start` with an operation code and, for software traps, an 8-bit trap number. The sequencer then makes its word accesses one after another on a simple request/ready memory port. It pulses `done` when the new context is in place. A trap return that is requested while the supervisor-stack flag is set is refused and flagged on `ret_err`.

Top module: `trap_seq`

## Requirements
- R1: After reset, `pc_out`, `ps_out` and `ssp_out` hold the reset parameter values, and `mem_req`, `done` and `ret_err` are 0.
- R2: Operation code 0 (software trap) first writes the status word to stack pointer − 4. It then writes program counter + 2 to stack pointer − 8. The stack pointer ends 8 lower.
- R3: A software trap with number n reads its vector from table base + 0x3FC − 4·n as its third access, and the word read is loaded into the program counter.
- R4: A software trap clears status bit 5 (supervisor-stack flag) and bit 4 (interrupt-enable flag) and leaves every other status bit unchanged.
- R5: Operation code 1 (emulator trap) makes the same two stack writes as R2. It reads its vector from table base + 0x3D8, loads that word into the program counter, and clears only status bit 5.
- R6: Operation code 2 (trap return) with status bit 5 at 0 reads the program counter from the stack pointer, then reads the status word from stack pointer + 4. The stack pointer ends 8 higher. Between accesses the stack pointer moves only in steps of 4.
- R7: A trap return requested while status bit 5 is 1 raises `ret_err` for exactly the next cycle. It makes no memory access, does not pulse `done`, and leaves the program counter, status word and stack pointer unchanged.
- R8: A memory access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_ready` is sampled high. `mem_we` is high only for the stack writes.
- R9: `done` is a single-cycle pulse. When `mem_ready` is held high, it comes 4 cycles after the `start` edge for a trap and 3 cycles after it for a trap return.
- R10: Operation code 3 does nothing. A `start` that arrives while an operation is in progress is ignored.
- R11: Every access address is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the operation on `op` (sampled while idle) |
| op | input | 2 | 0 software trap, 1 emulator trap, 2 trap return, 3 none |
| trap_num | input | 8 | Software trap number |
| mem_rdata | input | 32 | Read data, valid in the cycle `mem_ready` is high |
| mem_ready | input | 1 | Current access completes at this clock edge |
| mem_req | output | 1 | Access in progress |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| ret_err | output | 1 | Trap return refused because the supervisor-stack flag is set |
| pc_out | output | 32 | Program counter |
| ps_out | output | 32 | Status word |
| ssp_out | output | 32 | Supervisor stack pointer |

## Verification
The assertions assume that the memory answers each request in finite time and that `mem_ready` carries meaning only while `mem_req` is high. They also assume that the reset values of the stack pointer and table base are word aligned, which the alignment property depends on. The stimulus drives `mem_ready` from random stalls only and supplies data just for the cycle of completion. It keeps the reset parameters aligned and holds `start` beyond one cycle only in the test that checks a busy sequencer ignores it.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

   typedef enum logic [1:0] {
      OP_SWI  = 2'd0,
      OP_EMU  = 2'd1,
      OP_RET  = 2'd2,
      OP_NONE = 2'd3
   } trap_op_t;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_PS = 3'd1,
      ST_PUSH_PC = 3'd2,
      ST_VEC     = 3'd3,
      ST_POP_PC  = 3'd4,
      ST_POP_PS  = 3'd5,
      ST_DONE    = 3'd6
   } seq_state_t;

   function automatic logic st_is_push(seq_state_t s);
      return (s == ST_PUSH_PS) || (s == ST_PUSH_PC);
   endfunction

   function automatic logic st_is_pop(seq_state_t s);
      return (s == ST_POP_PC) || (s == ST_POP_PS);
   endfunction

   function automatic logic st_is_access(seq_state_t s);
      return st_is_push(s) || st_is_pop(s) || (s == ST_VEC);
   endfunction

endpackage

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
   parameter int          XLEN        = 32,
   parameter int          NUM_W       = 8,
   parameter logic [31:0] SWI_TOP_OFS = 32'h0000_03FC,
   parameter logic [31:0] EMU_OFS     = 32'h0000_03D8
) (
   input  logic [XLEN-1:0]  tbr,
   input  logic [NUM_W-1:0] num,
   input  logic             is_emu,
   output logic [XLEN-1:0]  vec_addr
);
   localparam int SLOT_BYTES = XLEN / 8;
   localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

   logic [XLEN-1:0] slot_ofs;
   logic [XLEN-1:0] swi_addr;
   logic [XLEN-1:0] emu_addr;

   assign slot_ofs = XLEN'(num) << SLOT_SHIFT;

   generate
      if (XLEN > 32) begin : g_wide
         assign swi_addr = tbr + XLEN'(SWI_TOP_OFS) - slot_ofs;
         assign emu_addr = tbr + XLEN'(EMU_OFS);
      end else begin : g_narrow
         assign swi_addr = tbr + SWI_TOP_OFS[XLEN-1:0] - slot_ofs;
         assign emu_addr = tbr + EMU_OFS[XLEN-1:0];
      end
   endgenerate

   assign vec_addr = is_emu ? emu_addr : swi_addr;

endmodule

// File: rtl/trap_ctx_regs.sv
module trap_ctx_regs #(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] RESET_PC  = '0,
   parameter logic [XLEN-1:0] RESET_PS  = '0,
   parameter logic [XLEN-1:0] RESET_SSP = '0,
   parameter logic [XLEN-1:0] RESET_TBR = '0,
   parameter int              S_BIT     = 5,
   parameter int              I_BIT     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ssp_dec,
   input  logic            ssp_inc,
   input  logic            pc_load,
   input  logic            ps_load,
   input  logic            clr_s,
   input  logic            clr_i,
   input  logic [XLEN-1:0] load_data,
   output logic [XLEN-1:0] pc_q,
   output logic [XLEN-1:0] ps_q,
   output logic [XLEN-1:0] ssp_q,
   output logic [XLEN-1:0] tbr_q
);
   localparam logic [XLEN-1:0] WORD = XLEN'(XLEN / 8);

   logic [XLEN-1:0] ps_next;
   logic [XLEN-1:0] ssp_next;

   always_comb begin
      ps_next = ps_q;
      if (ps_load) begin
         ps_next = load_data;
      end else begin
         if (clr_s) ps_next[S_BIT] = 1'b0;
         if (clr_i) ps_next[I_BIT] = 1'b0;
      end
   end

   always_comb begin
      ssp_next = ssp_q;
      if (ssp_dec)      ssp_next = ssp_q - WORD;
      else if (ssp_inc) ssp_next = ssp_q + WORD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         ps_q  <= RESET_PS;
         ssp_q <= RESET_SSP;
         tbr_q <= RESET_TBR;
      end else begin
         if (pc_load) pc_q <= load_data;
         ps_q  <= ps_next;
         ssp_q <= ssp_next;
         tbr_q <= tbr_q;
      end
   end

endmodule

// File: rtl/trap_ctrl_fsm.sv
module trap_ctrl_fsm
   import trap_seq_pkg::*;
#(
   parameter int NUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       op,
   input  logic [NUM_W-1:0] trap_num,
   input  logic             s_flag,
   input  logic             mem_ready,
   output seq_state_t       state,
   output logic             emu_q,
   output logic [NUM_W-1:0] num_q,
   output logic             ssp_dec,
   output logic             ssp_inc,
   output logic             pc_load,
   output logic             ps_load,
   output logic             clr_s,
   output logic             clr_i,
   output logic             ret_err,
   output logic             done
);
   trap_op_t   op_t;
   seq_state_t state_n;
   logic       fire;
   logic       accept;
   logic       err_n;

   assign op_t   = trap_op_t'(op);
   assign accept = (state == ST_IDLE) && start;
   assign fire   = st_is_access(state) && mem_ready;
   assign err_n  = accept && (op_t == OP_RET) && s_flag;

   always_comb begin
      state_n = state;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               unique case (op_t)
                  OP_SWI, OP_EMU: state_n = ST_PUSH_PS;
                  OP_RET:         state_n = s_flag ? ST_IDLE : ST_POP_PC;
                  default:        state_n = ST_IDLE;
               endcase
            end
         end
         ST_PUSH_PS: if (mem_ready) state_n = ST_PUSH_PC;
         ST_PUSH_PC: if (mem_ready) state_n = ST_VEC;
         ST_VEC:     if (mem_ready) state_n = ST_DONE;
         ST_POP_PC:  if (mem_ready) state_n = ST_POP_PS;
         ST_POP_PS:  if (mem_ready) state_n = ST_DONE;
         ST_DONE:    state_n = ST_IDLE;
         default:    state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         emu_q   <= 1'b0;
         num_q   <= '0;
         ret_err <= 1'b0;
      end else begin
         state   <= state_n;
         ret_err <= err_n;
         if (accept && ((op_t == OP_SWI) || (op_t == OP_EMU))) begin
            emu_q <= (op_t == OP_EMU);
            num_q <= trap_num;
         end
      end
   end

   assign ssp_dec = fire && st_is_push(state);
   assign ssp_inc = fire && st_is_pop(state);
   assign pc_load = fire && ((state == ST_VEC) || (state == ST_POP_PC));
   assign ps_load = fire && (state == ST_POP_PS);
   assign clr_s   = fire && (state == ST_VEC);
   assign clr_i   = fire && (state == ST_VEC) && !emu_q;
   assign done    = (state == ST_DONE);

endmodule

// File: rtl/trap_seq.sv
module trap_seq
   import trap_seq_pkg::*;
#(
   parameter int          XLEN        = 32,
   parameter int          NUM_W       = 8,
   parameter int          S_BIT       = 5,
   parameter int          I_BIT       = 4,
   parameter int          RET_OFS     = 2,
   parameter logic [31:0] SWI_TOP_OFS = 32'h0000_03FC,
   parameter logic [31:0] EMU_OFS     = 32'h0000_03D8,
   parameter logic [31:0] RESET_PC    = 32'h0000_0100,
   parameter logic [31:0] RESET_PS    = 32'h0001_00F3,
   parameter logic [31:0] RESET_SSP   = 32'h0000_2000,
   parameter logic [31:0] RESET_TBR   = 32'h0001_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       op,
   input  logic [NUM_W-1:0] trap_num,
   input  logic [XLEN-1:0]  mem_rdata,
   input  logic             mem_ready,
   output logic             mem_req,
   output logic             mem_we,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   output logic             done,
   output logic             ret_err,
   output logic [XLEN-1:0]  pc_out,
   output logic [XLEN-1:0]  ps_out,
   output logic [XLEN-1:0]  ssp_out
);
   localparam int              WORD_BYTES = XLEN / 8;
   localparam int              ALIGN_W    = $clog2(WORD_BYTES);
   localparam logic [XLEN-1:0] WORD       = XLEN'(WORD_BYTES);
   localparam logic [XLEN-1:0] RET_STEP   = XLEN'(RET_OFS);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("trap_seq: XLEN must be 32");
      end
      if ((S_BIT >= XLEN) || (I_BIT >= XLEN) || (S_BIT == I_BIT)) begin : g_bad_flags
         $error("trap_seq: flag bit positions invalid");
      end
      if ((RESET_SSP[ALIGN_W-1:0] != '0) || (RESET_TBR[ALIGN_W-1:0] != '0)) begin : g_bad_align
         $error("trap_seq: stack and table base must be word aligned");
      end
      if (NUM_W > 8) begin : g_bad_num
         $error("trap_seq: trap number wider than table allows");
      end
   endgenerate

   seq_state_t       state;
   logic             emu_q;
   logic [NUM_W-1:0] num_q;
   logic             ssp_dec, ssp_inc, pc_load, ps_load, clr_s, clr_i;
   logic [XLEN-1:0]  pc_q, ps_q, ssp_q, tbr_q;
   logic [XLEN-1:0]  vec_addr;

   trap_ctrl_fsm #(
      .NUM_W (NUM_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .op        (op),
      .trap_num  (trap_num),
      .s_flag    (ps_q[S_BIT]),
      .mem_ready (mem_ready),
      .state     (state),
      .emu_q     (emu_q),
      .num_q     (num_q),
      .ssp_dec   (ssp_dec),
      .ssp_inc   (ssp_inc),
      .pc_load   (pc_load),
      .ps_load   (ps_load),
      .clr_s     (clr_s),
      .clr_i     (clr_i),
      .ret_err   (ret_err),
      .done      (done)
   );

   trap_ctx_regs #(
      .XLEN      (XLEN),
      .RESET_PC  (RESET_PC[XLEN-1:0]),
      .RESET_PS  (RESET_PS[XLEN-1:0]),
      .RESET_SSP (RESET_SSP[XLEN-1:0]),
      .RESET_TBR (RESET_TBR[XLEN-1:0]),
      .S_BIT     (S_BIT),
      .I_BIT     (I_BIT)
   ) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .ssp_dec   (ssp_dec),
      .ssp_inc   (ssp_inc),
      .pc_load   (pc_load),
      .ps_load   (ps_load),
      .clr_s     (clr_s),
      .clr_i     (clr_i),
      .load_data (mem_rdata),
      .pc_q      (pc_q),
      .ps_q      (ps_q),
      .ssp_q     (ssp_q),
      .tbr_q     (tbr_q)
   );

   trap_vec_calc #(
      .XLEN        (XLEN),
      .NUM_W       (NUM_W),
      .SWI_TOP_OFS (SWI_TOP_OFS),
      .EMU_OFS     (EMU_OFS)
   ) u_vec (
      .tbr      (tbr_q),
      .num      (num_q),
      .is_emu   (emu_q),
      .vec_addr (vec_addr)
   );

   always_comb begin
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         ST_PUSH_PS: begin
            mem_addr  = ssp_q - WORD;
            mem_wdata = ps_q;
         end
         ST_PUSH_PC: begin
            mem_addr  = ssp_q - WORD;
            mem_wdata = pc_q + RET_STEP;
         end
         ST_VEC:                 mem_addr = vec_addr;
         ST_POP_PC, ST_POP_PS:   mem_addr = ssp_q;
         default: begin
            mem_addr  = '0;
            mem_wdata = '0;
         end
      endcase
   end

   assign mem_req = st_is_access(state);
   assign mem_we  = st_is_push(state);
   assign pc_out  = pc_q;
   assign ps_out  = ps_q;
   assign ssp_out = ssp_q;

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
   parameter int XLEN  = 32,
   parameter int S_BIT = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mem_ready,
   input logic            mem_req,
   input logic            mem_we,
   input logic [XLEN-1:0] mem_addr,
   input logic [XLEN-1:0] mem_wdata,
   input logic            done,
   input logic            ret_err,
   input logic [XLEN-1:0] pc_out,
   input logic [XLEN-1:0] ps_out,
   input logic [XLEN-1:0] ssp_out
);
   localparam int              ALIGN_W = $clog2(XLEN / 8);
   localparam logic [XLEN-1:0] WORD    = XLEN'(XLEN / 8);

   assert_write_in_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !mem_req);

   assert_refusal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_err |-> ($stable(pc_out) && $stable(ps_out) && $stable(ssp_out)
                   && !done && !mem_req && ps_out[S_BIT]));

   assert_stack_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ssp_out) |->
         ((ssp_out == $past(ssp_out) + WORD) || (ssp_out == $past(ssp_out) - WORD)));

   assert_word_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[ALIGN_W-1:0] == '0));

endmodule

bind trap_seq trap_seq_chk #(.XLEN(XLEN), .S_BIT(S_BIT)) u_trap_seq_chk (.*);

// File: tb/trap_seq_test.sv
module trap_seq_test;

   localparam logic [31:0] P_PC  = 32'h0000_0100;
   localparam logic [31:0] P_PS  = 32'h0001_00F3;
   localparam logic [31:0] P_SSP = 32'h0000_2000;
   localparam logic [31:0] P_TBR = 32'h0001_0000;

   typedef struct {
      bit          we;
      logic [31:0] a;
      logic [31:0] d;
   } acc_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd3;
   logic [7:0]  trap_num = 8'd0;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic        mem_req, mem_we, done, ret_err;
   logic [31:0] mem_addr, mem_wdata, pc_out, ps_out, ssp_out;

   int checks = 0;
   int errors = 0;
   bit stall_mode = 1'b0;
   bit finished = 1'b0;

   acc_t        exp_q[$];
   logic [31:0] mem     [logic [31:0]];
   logic [31:0] exp_mem [logic [31:0]];
   logic [31:0] m_pc, m_ps, m_ssp;

   always #10 clk = ~clk;

   trap_seq #(
      .RESET_PC (P_PC), .RESET_PS (P_PS), .RESET_SSP (P_SSP), .RESET_TBR (P_TBR)
   ) uut (
      .clk (clk), .rst_n (rst_n), .start (start), .op (op), .trap_num (trap_num),
      .mem_rdata (mem_rdata), .mem_ready (mem_ready), .mem_req (mem_req),
      .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .done (done), .ret_err (ret_err), .pc_out (pc_out), .ps_out (ps_out),
      .ssp_out (ssp_out)
   );

   function automatic logic [31:0] table_word(input logic [31:0] a);
      return a ^ 32'h3C00_0000;
   endfunction

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return table_word(a);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [31:0] a);
      if (exp_mem.exists(a)) return exp_mem[a];
      return table_word(a);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // memory responder and per-cycle access comparison (R8)
   always @(negedge clk) begin
      bit rdy;
      if (rst_n) begin
         if (mem_req) begin
            if (exp_q.size() == 0) begin
               chk("R10 unexpected access", mem_addr, 32'hFFFF_FFFF);
            end else begin
               chk("R8 access addr", mem_addr, exp_q[0].a);
               chk("R8 access we", {31'd0, mem_we}, {31'd0, exp_q[0].we});
               if (exp_q[0].we) chk("R2 write data", mem_wdata, exp_q[0].d);
            end
         end
         rdy = stall_mode ? (($urandom % 3) != 0) : 1'b1;
         mem_ready <= rdy;
         mem_rdata <= (mem_req && !mem_we) ? mem_rd(mem_addr) : 32'h0;
         if (mem_req && rdy) begin
            if (mem_we) mem[mem_addr] = mem_wdata;
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end
      end
   end

   task automatic check_ctx(input string req);
      chk({req, " pc"},  pc_out,  m_pc);
      chk({req, " ps"},  ps_out,  m_ps);
      chk({req, " ssp"}, ssp_out, m_ssp);
   endtask

   // run one operation; reqs names the requirement being exercised
   task automatic run_op(input logic [1:0] o, input logic [7:0] n, input bit stall,
                         input bit hold, input string req);
      int cyc;
      int want;
      acc_t e;
      stall_mode = stall;
      if (o == 2'd2) begin
         e.we = 0; e.a = m_ssp;     e.d = '0; exp_q.push_back(e);
         e.we = 0; e.a = m_ssp + 4; e.d = '0; exp_q.push_back(e);
         m_pc  = exp_rd(m_ssp);
         m_ps  = exp_rd(m_ssp + 4);
         m_ssp = m_ssp + 8;
         want  = 3;
      end else begin
         logic [31:0] va;
         va = (o == 2'd1) ? P_TBR + 32'h3D8 : P_TBR + 32'h3FC - {22'd0, n, 2'b00};
         e.we = 1; e.a = m_ssp - 4; e.d = m_ps;     exp_q.push_back(e);
         e.we = 1; e.a = m_ssp - 8; e.d = m_pc + 2; exp_q.push_back(e);
         e.we = 0; e.a = va;        e.d = '0;       exp_q.push_back(e);
         exp_mem[m_ssp - 4] = m_ps;
         exp_mem[m_ssp - 8] = m_pc + 2;
         m_ssp = m_ssp - 8;
         m_pc  = table_word(va);
         m_ps[5] = 1'b0;
         if (o == 2'd0) m_ps[4] = 1'b0;
         want  = 4;
      end
      @(negedge clk);
      start <= 1'b1; op <= o; trap_num <= n;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (!(hold && cyc == 1)) start <= 1'b0;
      end while (!done && cyc < 400);
      chk({req, " R9 done seen"}, {31'd0, done}, 32'd1);
      if (!stall && !hold) chk({req, " R9 latency"}, cyc, want);
      check_ctx(req);
      chk({req, " R8 all accesses made"}, exp_q.size(), 0);
      @(negedge clk);
      chk({req, " R9 done one cycle"}, {31'd0, done}, 32'd0);
   endtask

   task automatic run_refused(input string req);
      stall_mode = 1'b0;
      @(negedge clk);
      start <= 1'b1; op <= 2'd2;
      @(negedge clk);
      start <= 1'b0;
      chk({req, " err"}, {31'd0, ret_err}, 32'd1);
      chk({req, " no done"}, {31'd0, done}, 32'd0);
      chk({req, " no access"}, {31'd0, mem_req}, 32'd0);
      check_ctx(req);
      @(negedge clk);
      chk({req, " err one cycle"}, {31'd0, ret_err}, 32'd0);
      check_ctx(req);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
   end

   initial begin
      m_pc = P_PC; m_ps = P_PS; m_ssp = P_SSP;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_ctx("R1 reset");
      chk("R1 req", {31'd0, mem_req}, 32'd0);
      chk("R1 done", {31'd0, done}, 32'd0);
      chk("R1 err", {31'd0, ret_err}, 32'd0);

      // R7 return refused while supervisor-stack flag set
      run_refused("R7 after reset");

      // R10 op code 3 does nothing
      @(negedge clk);
      start <= 1'b1; op <= 2'd3;
      @(negedge clk);
      start <= 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R10 none op no done", {31'd0, done}, 32'd0);
      end
      check_ctx("R10 none op");

      // R2 R3 R4 software trap 0, no stalls
      run_op(2'd0, 8'd0, 1'b0, 1'b0, "R2 R3 R4 swi0");
      // R5 emulator trap with S already clear
      run_op(2'd1, 8'd0, 1'b0, 1'b0, "R5 emu");
      // R3 trap 255 with stalls and start held while busy (R10)
      run_op(2'd0, 8'd255, 1'b1, 1'b1, "R3 R10 swi255");
      // R6 returns unwind the nest
      run_op(2'd2, 8'd0, 1'b0, 1'b0, "R6 ret1");
      run_op(2'd2, 8'd0, 1'b1, 1'b0, "R6 ret2 stalled");
      run_op(2'd2, 8'd0, 1'b0, 1'b0, "R6 ret3");
      chk("R6 stack back at reset", ssp_out, P_SSP);
      // R7 restored status has S set again
      run_refused("R7 restored");
      // R5 emulator trap keeps I
      run_op(2'd1, 8'd0, 1'b1, 1'b0, "R5 emu keeps I");
      chk("R5 I kept", {31'd0, ps_out[4]}, 32'd1);
      // R3 R4 software trap 1
      run_op(2'd0, 8'd1, 1'b0, 1'b0, "R3 R4 swi1");
      chk("R4 I cleared", {31'd0, ps_out[4]}, 32'd0);
      repeat (3) @(negedge clk);
      summary();
   end

endmodule